// File: doc/BRIEF.md
# PWM Fault Override Controller

This block sits between a multi-pair PWM generator and the output pins. When one of two active-low fault inputs goes low, it replaces the generator's levels on selected pins with programmed safe states. Each fault source has its own set of pair enables, its own per-pin override levels and its own recovery mode. A per-pin polarity bit maps the active and inactive levels onto the electrical pin level. This mapping applies to both normal and overridden output.

The override starts as soon as the synchronized fault level is seen. It ends only on a PWM cycle or half-cycle boundary strobe, so a pulse is never cut short mid-period on recovery. Each fault also keeps a sticky interrupt flag. The flag works whether or not the fault drives any pins, and in latched mode it takes part in recovery. In a pair that runs complementary, the high-side pin wins if both pins are programmed active. When both faults claim the same pair, fault A has priority over fault B.

Top module: `pwm_fault_override`

## Requirements
- R1: A fault input counts as asserted while low. After a two-stage synchronizer, the override appears at the pins after the second rising clock edge following the falling input, with no wait for a boundary; after only one edge the pins still show normal output.
- R2: Fault f overrides pair p only if `flt_pair_en_i[f*NPAIRS+p]` is 1 (fault A is f=0, fault B is f=1). Pairs that are not enabled keep their generator levels.
- R3: The override level of pair p under fault f comes from `flt_state_i[f*2*NPAIRS + 2p]` for the high-side pin and `flt_state_i[f*2*NPAIRS + 2p + 1]` for the low-side pin. A 1 selects the active level and a 0 selects the inactive level.
- R4: Pin level = active-level XOR NOT polarity, with polarity 1 meaning active-high. The same rule applies to normal and overridden output, per pin, through `pol_hi_i`/`pol_lo_i`.
- R5: In a pair with `comp_mode_i[p]`=1 that is under override, if both pins are programmed active, the low-side pin is forced inactive. Both pins are never active together.
- R6: When both faults are in force on the same pair, fault A's override levels are used.
- R7: In latched mode (`flt_cbc_i[f]`=0), the override ends only after three conditions: the fault input is back high, the fault's flag has been cleared, and a boundary strobe has arrived. The first two may occur in either order.
- R8: In cycle-by-cycle mode (`flt_cbc_i[f]`=1), the override ends at the first cycle or half-cycle boundary strobe seen after the synchronized input is high. The pins show normal output from the clock edge that samples that strobe onward.
- R9: `flt_flag_o[f]` sets on the synchronized falling edge of fault f and stays set until a `flag_clr_i[f]` pulse. If a set and a clear happen in the same cycle, the set wins.
- R10: A fault whose pair enables are all zero has no effect on the pins, but its flag still operates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_hi_i | input | NPAIRS | Generator high-side active levels, one per pair |
| pwm_lo_i | input | NPAIRS | Generator low-side active levels, one per pair |
| flt_n_i | input | 2 | Fault inputs, active low; bit 0 = A, bit 1 = B |
| flt_pair_en_i | input | 2*NPAIRS | Pair enables; fault f at bits [f*NPAIRS +: NPAIRS] |
| flt_state_i | input | 4*NPAIRS | Override levels; fault f at [f*2*NPAIRS +: 2*NPAIRS], pair p high at 2p, low at 2p+1 |
| flt_cbc_i | input | 2 | Recovery mode per fault: 1 cycle-by-cycle, 0 latched |
| pol_hi_i | input | NPAIRS | High-side polarity, 1 = active-high |
| pol_lo_i | input | NPAIRS | Low-side polarity, 1 = active-high |
| comp_mode_i | input | NPAIRS | Complementary-mode flag per pair |
| cyc_bnd_i | input | 1 | PWM cycle boundary strobe |
| half_bnd_i | input | 1 | PWM half-cycle boundary strobe |
| flag_clr_i | input | 2 | Flag-clear pulses per fault |
| pin_hi_o | output | NPAIRS | Final high-side pin levels |
| pin_lo_o | output | NPAIRS | Final low-side pin levels |
| flt_flag_o | output | 2 | Sticky interrupt flags per fault |

## Verification
The assertions assume that the recovery mode of a fault does not change while that fault's override is pending. A mode change at that point would make the latched-mode check look at the wrong rule. The checks on complementary and disabled pairs compare pins against configuration inputs in the same cycle, so they assume configuration is static around each clock edge. The stimulus writes every configuration field between faults, only at the falling clock edge, and each scenario ends with a full release sequence before the next one reprograms the block.

// File: rtl/pfo_pkg.sv
package pfo_pkg;
    localparam int NFLT  = 2;
    localparam int FLT_A = 0;
    localparam int FLT_B = 1;

    typedef struct packed {
        logic sync1;
        logic sync2;
        logic flag;
        logic hold;
    } chan_state_t;

    localparam chan_state_t CHAN_RESET = '{sync1: 1'b1, sync2: 1'b1, flag: 1'b0, hold: 1'b0};
endpackage

// File: rtl/pfo_fault_chan.sv
module pfo_fault_chan
    import pfo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flt_n_i,
    input  logic cbc_i,
    input  logic bnd_i,
    input  logic clr_i,
    output logic flag_o,
    output logic hold_o,
    output logic ovr_o
);
    chan_state_t st_d, st_q;
    logic        asserted;
    logic        fell;
    logic        release_ok;

    always_comb begin
        st_d       = st_q;
        asserted   = ~st_q.sync2;
        fell       = st_q.sync2 & ~st_q.sync1;
        release_ok = cbc_i | ~st_q.flag;

        st_d.sync1 = flt_n_i;
        st_d.sync2 = st_q.sync1;

        if (fell) begin
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end

        if (asserted) begin
            st_d.hold = 1'b1;
        end else if (st_q.hold && bnd_i && release_ok) begin
            st_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CHAN_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign hold_o = st_q.hold;
    assign ovr_o  = ~st_q.sync2 | st_q.hold;
endmodule

// File: rtl/pfo_pair_mux.sv
module pfo_pair_mux (
    input  logic       raw_hi_i,
    input  logic       raw_lo_i,
    input  logic       sel_a_i,
    input  logic       sel_b_i,
    input  logic [1:0] st_a_i,
    input  logic [1:0] st_b_i,
    input  logic       comp_i,
    input  logic       pol_hi_i,
    input  logic       pol_lo_i,
    output logic       pin_hi_o,
    output logic       pin_lo_o
);
    logic act_hi;
    logic act_lo;

    always_comb begin
        act_hi = raw_hi_i;
        act_lo = raw_lo_i;
        if (sel_a_i) begin
            act_hi = st_a_i[0];
            act_lo = st_a_i[1];
        end else if (sel_b_i) begin
            act_hi = st_b_i[0];
            act_lo = st_b_i[1];
        end
        if ((sel_a_i || sel_b_i) && comp_i && act_hi) begin
            act_lo = 1'b0;
        end
        pin_hi_o = act_hi ^ ~pol_hi_i;
        pin_lo_o = act_lo ^ ~pol_lo_i;
    end
endmodule

// File: rtl/pwm_fault_override.sv
module pwm_fault_override
    import pfo_pkg::*;
#(
    parameter int NPAIRS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPAIRS-1:0]     pwm_hi_i,
    input  logic [NPAIRS-1:0]     pwm_lo_i,
    input  logic [NFLT-1:0]       flt_n_i,
    input  logic [2*NPAIRS-1:0]   flt_pair_en_i,
    input  logic [4*NPAIRS-1:0]   flt_state_i,
    input  logic [NFLT-1:0]       flt_cbc_i,
    input  logic [NPAIRS-1:0]     pol_hi_i,
    input  logic [NPAIRS-1:0]     pol_lo_i,
    input  logic [NPAIRS-1:0]     comp_mode_i,
    input  logic                  cyc_bnd_i,
    input  logic                  half_bnd_i,
    input  logic [NFLT-1:0]       flag_clr_i,
    output logic [NPAIRS-1:0]     pin_hi_o,
    output logic [NPAIRS-1:0]     pin_lo_o,
    output logic [NFLT-1:0]       flt_flag_o
);
    localparam int NPINS = 2 * NPAIRS;

    logic            bnd;
    logic [NFLT-1:0] hold_q;
    logic [NFLT-1:0] ovr_eff;

    assign bnd = cyc_bnd_i | half_bnd_i;

    for (genvar f = 0; f < NFLT; f++) begin : g_chan
        pfo_fault_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .flt_n_i (flt_n_i[f]),
            .cbc_i   (flt_cbc_i[f]),
            .bnd_i   (bnd),
            .clr_i   (flag_clr_i[f]),
            .flag_o  (flt_flag_o[f]),
            .hold_o  (hold_q[f]),
            .ovr_o   (ovr_eff[f])
        );
    end

    for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
        logic sel_a;
        logic sel_b;
        assign sel_a = ovr_eff[FLT_A] & flt_pair_en_i[FLT_A*NPAIRS + p];
        assign sel_b = ovr_eff[FLT_B] & flt_pair_en_i[FLT_B*NPAIRS + p];

        pfo_pair_mux u_mux (
            .raw_hi_i (pwm_hi_i[p]),
            .raw_lo_i (pwm_lo_i[p]),
            .sel_a_i  (sel_a),
            .sel_b_i  (sel_b),
            .st_a_i   (flt_state_i[FLT_A*NPINS + 2*p +: 2]),
            .st_b_i   (flt_state_i[FLT_B*NPINS + 2*p +: 2]),
            .comp_i   (comp_mode_i[p]),
            .pol_hi_i (pol_hi_i[p]),
            .pol_lo_i (pol_lo_i[p]),
            .pin_hi_o (pin_hi_o[p]),
            .pin_lo_o (pin_lo_o[p])
        );
    end
endmodule

// File: rtl/pfo_checker.sv
module pfo_checker
    import pfo_pkg::*;
#(
    parameter int NPAIRS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NPAIRS-1:0]   pwm_hi_i,
    input logic [NPAIRS-1:0]   pwm_lo_i,
    input logic [2*NPAIRS-1:0] flt_pair_en_i,
    input logic [NFLT-1:0]     flt_cbc_i,
    input logic [NPAIRS-1:0]   pol_hi_i,
    input logic [NPAIRS-1:0]   pol_lo_i,
    input logic [NPAIRS-1:0]   comp_mode_i,
    input logic                cyc_bnd_i,
    input logic                half_bnd_i,
    input logic [NFLT-1:0]     flag_clr_i,
    input logic [NPAIRS-1:0]   pin_hi_o,
    input logic [NPAIRS-1:0]   pin_lo_o,
    input logic [NFLT-1:0]     flt_flag_o,
    input logic [NFLT-1:0]     hold_q,
    input logic [NFLT-1:0]     ovr_eff
);
    for (genvar f = 0; f < NFLT; f++) begin : g_f
        assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (flt_flag_o[f] && !flag_clr_i[f]) |=> flt_flag_o[f]);

        assert_exit_on_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(hold_q[f]) |-> $past(cyc_bnd_i || half_bnd_i));

        assert_latched_exit_needs_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(hold_q[f]) && !$past(flt_cbc_i[f])) |-> !$past(flt_flag_o[f]));
    end

    for (genvar p = 0; p < NPAIRS; p++) begin : g_p
        logic act_hi;
        logic act_lo;
        logic pair_ovr;
        assign act_hi   = pin_hi_o[p] ^ ~pol_hi_i[p];
        assign act_lo   = pin_lo_o[p] ^ ~pol_lo_i[p];
        assign pair_ovr = (ovr_eff[FLT_A] & flt_pair_en_i[FLT_A*NPAIRS + p]) |
                          (ovr_eff[FLT_B] & flt_pair_en_i[FLT_B*NPAIRS + p]);

        assert_comp_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (comp_mode_i[p] && pair_ovr) |-> !(act_hi && act_lo));

        assert_disabled_passthrough_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (flt_pair_en_i == '0) |-> (act_hi == pwm_hi_i[p] && act_lo == pwm_lo_i[p]));
    end
endmodule

bind pwm_fault_override pfo_checker #(.NPAIRS(NPAIRS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwm_hi_i      (pwm_hi_i),
    .pwm_lo_i      (pwm_lo_i),
    .flt_pair_en_i (flt_pair_en_i),
    .flt_cbc_i     (flt_cbc_i),
    .pol_hi_i      (pol_hi_i),
    .pol_lo_i      (pol_lo_i),
    .comp_mode_i   (comp_mode_i),
    .cyc_bnd_i     (cyc_bnd_i),
    .half_bnd_i    (half_bnd_i),
    .flag_clr_i    (flag_clr_i),
    .pin_hi_o      (pin_hi_o),
    .pin_lo_o      (pin_lo_o),
    .flt_flag_o    (flt_flag_o),
    .hold_q        (hold_q),
    .ovr_eff       (ovr_eff)
);

// File: tb/pwm_fault_override_tb.sv
module pwm_fault_override_tb;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pwm_hi = 4'b1010;
    logic [NP-1:0] pwm_lo = 4'b0101;
    logic [1:0]    flt_n = 2'b11;
    logic [2*NP-1:0] en = '0;
    logic [4*NP-1:0] st = '0;
    logic [1:0]    cbc = 2'b11;
    logic [NP-1:0] pol_hi = '1;
    logic [NP-1:0] pol_lo = '1;
    logic [NP-1:0] comp = '0;
    logic          cyc_bnd = 1'b0;
    logic          half_bnd = 1'b0;
    logic [1:0]    clr = 2'b00;
    logic [NP-1:0] pin_hi, pin_lo;
    logic [1:0]    flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwm_fault_override #(.NPAIRS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_hi_i(pwm_hi), .pwm_lo_i(pwm_lo),
        .flt_n_i(flt_n), .flt_pair_en_i(en), .flt_state_i(st), .flt_cbc_i(cbc),
        .pol_hi_i(pol_hi), .pol_lo_i(pol_lo), .comp_mode_i(comp),
        .cyc_bnd_i(cyc_bnd), .half_bnd_i(half_bnd), .flag_clr_i(clr),
        .pin_hi_o(pin_hi), .pin_lo_o(pin_lo), .flt_flag_o(flag)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pins(input string tag, input logic [NP-1:0] eh, input logic [NP-1:0] el);
        check({tag, " hi"}, 32'(pin_hi), 32'(eh));
        check({tag, " lo"}, 32'(pin_lo), 32'(el));
    endtask

    task automatic release_all();
        flt_n = 2'b11;
        tick(3);
        clr = 2'b11;
        tick(1);
        clr = 2'b00;
        cyc_bnd = 1'b1;
        tick(1);
        cyc_bnd = 1'b0;
        tick(1);
    endtask

    task automatic t_reset();
        pins("R4 reset pins", 4'b1010, 4'b0101);
        check("R9 reset flags", 32'(flag), 32'h0);
    endtask

    task automatic t_cbc();
        en = {4'b0000, 4'b0011}; st = {8'h00, 8'h09}; cbc = 2'b01;
        flt_n = 2'b10;
        tick(1);
        pins("R1 one edge no override", 4'b1010, 4'b0101);
        tick(1);
        pins("R1 R2 R3 override", 4'b1001, 4'b0110);
        check("R9 flag set", 32'(flag), 32'h1);
        flt_n = 2'b11;
        tick(5);
        pins("R8 hold until boundary", 4'b1001, 4'b0110);
        half_bnd = 1'b1; tick(1); half_bnd = 1'b0;
        pins("R8 released at half boundary", 4'b1010, 4'b0101);
        check("R9 flag kept", 32'(flag), 32'h1);
        clr = 2'b01; tick(1); clr = 2'b00;
        check("R9 flag cleared", 32'(flag), 32'h0);
    endtask

    task automatic t_latched_pin_first();
        en = {4'b0000, 4'b0011}; st = {8'h00, 8'h09}; cbc = 2'b00;
        flt_n = 2'b10; tick(2);
        pins("R7 latched entry", 4'b1001, 4'b0110);
        flt_n = 2'b11; tick(3);
        cyc_bnd = 1'b1; tick(1); cyc_bnd = 1'b0;
        pins("R7 flag blocks exit", 4'b1001, 4'b0110);
        clr = 2'b01; tick(1); clr = 2'b00;
        check("R7 flag cleared", 32'(flag), 32'h0);
        pins("R7 waits for boundary", 4'b1001, 4'b0110);
        cyc_bnd = 1'b1; tick(1); cyc_bnd = 1'b0;
        pins("R7 exit pin-first order", 4'b1010, 4'b0101);
    endtask

    task automatic t_latched_clear_first();
        flt_n = 2'b10; tick(2);
        clr = 2'b01; tick(1); clr = 2'b00;
        check("R7 clear while low", 32'(flag), 32'h0);
        cyc_bnd = 1'b1; tick(1); cyc_bnd = 1'b0;
        pins("R7 pin low blocks exit", 4'b1001, 4'b0110);
        flt_n = 2'b11; tick(2);
        pins("R7 no boundary yet", 4'b1001, 4'b0110);
        cyc_bnd = 1'b1; tick(1); cyc_bnd = 1'b0;
        pins("R7 exit clear-first order", 4'b1010, 4'b0101);
    endtask

    task automatic t_priority();
        en = {4'b0101, 4'b0001}; st = {8'h32, 8'h01}; cbc = 2'b11;
        flt_n = 2'b01; tick(2);
        pins("R6 fault B alone", 4'b1110, 4'b0101);
        check("R9 flag B", 32'(flag), 32'h2);
        flt_n = 2'b00; tick(2);
        pins("R6 fault A wins", 4'b1111, 4'b0100);
        release_all();
        pins("R6 released", 4'b1010, 4'b0101);
    endtask

    task automatic t_comp();
        comp = 4'b0010; en = {4'b0000, 4'b1010}; st = {8'h00, 8'hCC}; cbc = 2'b11;
        flt_n = 2'b10; tick(2);
        pins("R5 high side wins", 4'b1010, 4'b1101);
        release_all();
        comp = 4'b0000;
    endtask

    task automatic t_polarity();
        pol_hi = 4'b0000; tick(1);
        pins("R4 normal inverted", 4'b0101, 4'b0101);
        en = {4'b0000, 4'b0001}; st = {8'h00, 8'h01}; cbc = 2'b11;
        flt_n = 2'b10; tick(2);
        pins("R4 override inverted", 4'b0100, 4'b0100);
        release_all();
        pol_hi = 4'b1111;
    endtask

    task automatic t_disabled();
        en = '0; st = {8'hFF, 8'hFF}; cbc = 2'b11;
        flt_n = 2'b10; tick(2);
        pins("R10 no effect", 4'b1010, 4'b0101);
        check("R10 flag still sets", 32'(flag), 32'h1);
        tick(4);
        check("R9 flag holds", 32'(flag), 32'h1);
        flt_n = 2'b11; tick(2);
        clr = 2'b01; tick(1);
        check("R9 clear", 32'(flag), 32'h0);
        flt_n = 2'b10; tick(2);
        check("R9 set beats clear", 32'(flag), 32'h1);
        clr = 2'b00;
        release_all();
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_cbc();
        t_latched_pin_first();
        t_latched_clear_first();
        t_priority();
        t_comp();
        t_polarity();
        t_disabled();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule